// File: doc/BRIEF.md
# Text-To-Column LCD Renderer

This engine turns a stream of ASCII characters into the byte stream that a page-addressed monochrome LCD expects. Every character becomes a six-column cell: five columns from a built-in 5x7 glyph set, then one blank spacer column. The column bytes are packed four to a 32-bit word and handed to a downstream serial interface. A separate locate request moves the text cursor by sending the page-select command and the two column-address commands for pixel column x*6.

Characters are offered one at a time over a valid/ready handshake. A last-character flag ends a string, and any partly filled word is then padded with zero bytes and sent. Output words carry a tag that tells the serial link whether the word is a command or display data. When the link stalls, the block holds its output word and stops taking new input, so no byte is lost.

Top module: `lcd_text_render`

## Requirements
- R1: After reset, out_valid is low and both ch_ready and loc_ready are high.
- R2: An accepted locate request at (x, y) produces three command beats in this order: 0xB0 OR (y AND 3), then 0x10 OR bits 7:4 of col, then 0x00 OR bits 3:0 of col, where col = (x*6) mod 256. Each command beat has out_cmd = 1, the command in out_word bits 7:0 and zero in bits 31:8.
- R3: An accepted character produces six data bytes: its five glyph columns from left to right, then one 0x00 spacer byte. In a glyph byte, bit 0 is the top pixel row, bit 6 the bottom row and bit 7 is zero.
- R4: For codes 32 to 127 the glyph is entry (code - 32) of the built-in 5x7 set (for example 'A' gives 7E 11 11 11 7E and code 127 gives 00 00 07 05 07).
- R5: A code below 32 or above 127 is drawn as the space glyph (five zero columns).
- R6: Data bytes are packed four per word with out_cmd = 0; the first byte of a group sits in out_word bits 31:24 and the fourth in bits 7:0.
- R7: When the character flagged ch_last has been rendered and the current word holds one to three bytes, that word is sent padded with zero bytes in its low positions; when the word is exactly full, no extra word is sent.
- R8: While out_valid is high and out_ready is low, out_valid, out_cmd and out_word stay unchanged, and every word is delivered exactly once.
- R9: ch_ready is low while a character or locate request is being worked on or the output is stalled; loc_ready is also low while the current data word holds one to three unsent bytes. When both requests are acceptable, the locate request is taken first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch_valid | input | 1 | Character offered |
| ch_code | input | 8 | ASCII code of the character |
| ch_last | input | 1 | Character ends the string; flush a partial word afterwards |
| ch_ready | output | 1 | Character accepted when high together with ch_valid |
| loc_valid | input | 1 | Locate request offered |
| loc_x | input | X_W | Text column of the cursor |
| loc_y | input | 2 | Text row, selects the display page |
| loc_ready | output | 1 | Locate request accepted when high together with loc_valid |
| out_valid | output | 1 | Output word present |
| out_cmd | output | 1 | 1: command beat, 0: data word |
| out_word | output | 32 | Command byte or four packed column bytes |
| out_ready | input | 1 | Downstream takes the word when high together with out_valid |

## Verification
A wrong step count in the sequencer shows up on the output within one character time (six cycles plus one) as a column shifted into the wrong byte lane or as a missing spacer byte. A wrong fill count in the packer makes every later word misaligned, and it makes a zero-padded word appear or go missing at the end of a string. Stall faults show within a single stalled cycle, as a changed or dropped word while out_ready is low, and the bench counts every such event.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;

  localparam int GLYPH_COLS = 5;
  localparam int CELL_COLS  = GLYPH_COLS + 1;
  localparam int GLYPH_W    = GLYPH_COLS * 8;
  localparam int FIRST_CODE = 32;
  localparam int LAST_CODE  = 127;
  localparam int COL_W      = 8;
  localparam int PAGE_W     = 2;
  localparam int WORD_W     = 32;
  localparam int STEP_W     = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_COLS,
    ST_PAD
  } seq_st_e;

  // Two glyphs per entry: even code in bits 79:40, odd code in bits 39:0.
  // Within a glyph the leftmost column occupies the top byte.
  function automatic logic [79:0] glyph_pair(input logic [5:0] p);
    logic [79:0] r;
    case (p)
      6'd0:  r = 80'h0000000000_00005F0000;
      6'd1:  r = 80'h0007000700_147F147F14;
      6'd2:  r = 80'h242A7F2A12_2313086462;
      6'd3:  r = 80'h3649552250_0005030000;
      6'd4:  r = 80'h001C224100_0041221C00;
      6'd5:  r = 80'h082A1C2A08_08083E0808;
      6'd6:  r = 80'h0050300000_0808080808;
      6'd7:  r = 80'h0060600000_2010080402;
      6'd8:  r = 80'h3E5149453E_00427F4000;
      6'd9:  r = 80'h4261514946_2141454B31;
      6'd10: r = 80'h1814127F10_2745454539;
      6'd11: r = 80'h3C4A494930_0171090503;
      6'd12: r = 80'h3649494936_064949291E;
      6'd13: r = 80'h0036360000_0056360000;
      6'd14: r = 80'h0008142241_1414141414;
      6'd15: r = 80'h4122140800_0201510906;
      6'd16: r = 80'h324979413E_7E1111117E;
      6'd17: r = 80'h7F49494936_3E41414122;
      6'd18: r = 80'h7F4141221C_7F49494941;
      6'd19: r = 80'h7F09090101_3E41415132;
      6'd20: r = 80'h7F0808087F_00417F4100;
      6'd21: r = 80'h2040413F01_7F08142241;
      6'd22: r = 80'h7F40404040_7F0204027F;
      6'd23: r = 80'h7F0408107F_3E4141413E;
      6'd24: r = 80'h7F09090906_3E4151215E;
      6'd25: r = 80'h7F09192946_4649494931;
      6'd26: r = 80'h01017F0101_3F4040403F;
      6'd27: r = 80'h1F2040201F_7F2018207F;
      6'd28: r = 80'h6314081463_0304780403;
      6'd29: r = 80'h6151494543_00007F4141;
      6'd30: r = 80'h0204081020_41417F0000;
      6'd31: r = 80'h0402010204_4040404040;
      6'd32: r = 80'h0001020400_2054545478;
      6'd33: r = 80'h7F48444438_3844444420;
      6'd34: r = 80'h384444487F_3854545418;
      6'd35: r = 80'h087E090102_081454543C;
      6'd36: r = 80'h7F08040478_00447D4000;
      6'd37: r = 80'h2040443D00_007F102844;
      6'd38: r = 80'h00417F4000_7C04180478;
      6'd39: r = 80'h7C08040478_3844444438;
      6'd40: r = 80'h7C14141408_081414187C;
      6'd41: r = 80'h7C08040408_4854545420;
      6'd42: r = 80'h043F444020_3C4040207C;
      6'd43: r = 80'h1C2040201C_3C4030403C;
      6'd44: r = 80'h4428102844_0C5050503C;
      6'd45: r = 80'h4464544C44_0008364100;
      6'd46: r = 80'h00007F0000_0041360800;
      6'd47: r = 80'h2010201000_0000070507;
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lcdr_font_rom.sv
module lcdr_font_rom
  import lcdr_pkg::*;
(
  input  logic [7:0]         code,
  output logic [GLYPH_W-1:0] glyph
);

  logic       in_range;
  logic [6:0] idx;
  logic [79:0] pair;

  always_comb begin
    in_range = (code >= 8'(FIRST_CODE)) && (code <= 8'(LAST_CODE));
    // Unprintable codes fall back to entry 0, the blank glyph.
    idx      = in_range ? 7'(code - 8'(FIRST_CODE)) : 7'd0;
    pair     = glyph_pair(idx[6:1]);
    glyph    = idx[0] ? pair[39:0] : pair[79:40];
  end

endmodule

// File: rtl/lcdr_seq.sv
module lcdr_seq
  import lcdr_pkg::*;
#(
  parameter int X_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [1:0]         fill,
  input  logic               ch_valid,
  input  logic               ch_last,
  input  logic [GLYPH_W-1:0] ch_glyph,
  output logic               ch_ready,
  input  logic               loc_valid,
  input  logic [X_W-1:0]     loc_x,
  input  logic [PAGE_W-1:0]  loc_y,
  output logic               loc_ready,
  output logic               push,
  output logic [7:0]         push_byte,
  output logic               flush,
  output logic               cmd_emit,
  output logic [7:0]         cmd_byte
);

  localparam logic [STEP_W-1:0] LAST_CMD_STEP = STEP_W'(2);
  localparam logic [STEP_W-1:0] LAST_COL_STEP = STEP_W'(CELL_COLS - 1);

  seq_st_e              st_q, st_n;
  logic [STEP_W-1:0]    step_q, step_n;
  logic [GLYPH_W-1:0]   gl_q, gl_n;
  logic                 last_q, last_n;
  logic [PAGE_W-1:0]    page_q, page_n;
  logic [COL_W-1:0]     col_q, col_n;
  logic [COL_W-1:0]     col_calc;
  logic                 fill_empty;

  always_comb begin
    col_calc   = COL_W'(loc_x * CELL_COLS);
    fill_empty = (fill == 2'd0);

    st_n      = st_q;
    step_n    = step_q;
    gl_n      = gl_q;
    last_n    = last_q;
    page_n    = page_q;
    col_n     = col_q;
    ch_ready  = 1'b0;
    loc_ready = 1'b0;
    push      = 1'b0;
    push_byte = gl_q[GLYPH_W-1 -: 8];
    flush     = 1'b0;
    cmd_emit  = 1'b0;
    cmd_byte  = 8'h00;

    case (st_q)
      ST_IDLE: begin
        loc_ready = adv && fill_empty;
        ch_ready  = adv && !(loc_valid && fill_empty);
        if (loc_valid && loc_ready) begin
          st_n   = ST_CMD;
          step_n = '0;
          page_n = loc_y;
          col_n  = col_calc;
        end else if (ch_valid && ch_ready) begin
          st_n   = ST_COLS;
          step_n = '0;
          gl_n   = ch_glyph;
          last_n = ch_last;
        end
      end
      ST_CMD: begin
        case (step_q)
          STEP_W'(0): cmd_byte = 8'hB0 | {6'd0, page_q};
          STEP_W'(1): cmd_byte = 8'h10 | {4'd0, col_q[7:4]};
          default:    cmd_byte = {4'd0, col_q[3:0]};
        endcase
        if (adv) begin
          cmd_emit = 1'b1;
          step_n   = step_q + STEP_W'(1);
          if (step_q == LAST_CMD_STEP) st_n = ST_IDLE;
        end
      end
      ST_COLS: begin
        if (adv) begin
          push   = 1'b1;
          // Shift out the leftmost column; after five shifts only zeros remain,
          // which supplies the spacer byte.
          gl_n   = {gl_q[GLYPH_W-9:0], 8'h00};
          step_n = step_q + STEP_W'(1);
          if (step_q == LAST_COL_STEP) begin
            st_n = (last_q && fill != 2'd3) ? ST_PAD : ST_IDLE;
          end
        end
      end
      ST_PAD: begin
        if (adv) begin
          flush = 1'b1;
          st_n  = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      gl_q   <= '0;
      last_q <= 1'b0;
      page_q <= '0;
      col_q  <= '0;
    end else begin
      st_q   <= st_n;
      step_q <= step_n;
      gl_q   <= gl_n;
      last_q <= last_n;
      page_q <= page_n;
      col_q  <= col_n;
    end
  end

  // R7: a padded word is only requested when the packer holds a partial word.
  p_flush_partial_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (fill != 2'd0));

endmodule

// File: rtl/lcdr_packer.sv
module lcdr_packer
  import lcdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [7:0]        push_byte,
  input  logic              flush,
  output logic [1:0]        fill,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);

  logic [23:0] acc_q, acc_n;
  logic [1:0]  fill_q, fill_n;
  logic        en;

  always_comb begin
    acc_n      = acc_q;
    fill_n     = fill_q;
    word_valid = 1'b0;
    word       = {acc_q, push_byte};
    en         = push || flush;
    if (push) begin
      if (fill_q == 2'd3) begin
        word_valid = 1'b1;
        fill_n     = 2'd0;
      end else begin
        acc_n  = {acc_q[15:0], push_byte};
        fill_n = fill_q + 2'd1;
      end
    end else if (flush) begin
      word_valid = 1'b1;
      fill_n     = 2'd0;
      case (fill_q)
        2'd1:    word = {acc_q[7:0], 24'h0};
        2'd2:    word = {acc_q[15:0], 16'h0};
        default: word = {acc_q, 8'h0};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (en) begin
      acc_q  <= acc_n;
      fill_q <= fill_n;
    end
  end

  assign fill = fill_q;

endmodule

// File: rtl/lcd_text_render.sv
module lcd_text_render
  import lcdr_pkg::*;
#(
  parameter int X_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_valid,
  input  logic [7:0]        ch_code,
  input  logic              ch_last,
  output logic              ch_ready,
  input  logic              loc_valid,
  input  logic [X_W-1:0]    loc_x,
  input  logic [PAGE_W-1:0] loc_y,
  output logic              loc_ready,
  output logic              out_valid,
  output logic              out_cmd,
  output logic [WORD_W-1:0] out_word,
  input  logic              out_ready
);

  logic [1:0]          rst_sync_q;
  logic                rst_q;
  logic [GLYPH_W-1:0]  glyph;
  logic                adv;
  logic [1:0]          fill;
  logic                push, flush, cmd_emit, word_valid;
  logic [7:0]          push_byte, cmd_byte;
  logic [WORD_W-1:0]   word;
  logic                ov_q, ov_n, oc_q, oc_n;
  logic [WORD_W-1:0]   ow_q, ow_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  assign adv = !ov_q || out_ready;

  lcdr_font_rom u_rom (
    .code  (ch_code),
    .glyph (glyph)
  );

  lcdr_seq #(.X_W(X_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q),
    .adv       (adv),
    .fill      (fill),
    .ch_valid  (ch_valid),
    .ch_last   (ch_last),
    .ch_glyph  (glyph),
    .ch_ready  (ch_ready),
    .loc_valid (loc_valid),
    .loc_x     (loc_x),
    .loc_y     (loc_y),
    .loc_ready (loc_ready),
    .push      (push),
    .push_byte (push_byte),
    .flush     (flush),
    .cmd_emit  (cmd_emit),
    .cmd_byte  (cmd_byte)
  );

  lcdr_packer u_pack (
    .clk        (clk),
    .rst_n      (rst_q),
    .push       (push),
    .push_byte  (push_byte),
    .flush      (flush),
    .fill       (fill),
    .word_valid (word_valid),
    .word       (word)
  );

  always_comb begin
    ov_n = ov_q;
    oc_n = oc_q;
    ow_n = ow_q;
    if (adv) begin
      ov_n = cmd_emit || word_valid;
      oc_n = cmd_emit;
      ow_n = cmd_emit ? {24'h0, cmd_byte} : word;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ov_q <= 1'b0;
      oc_q <= 1'b0;
      ow_q <= '0;
    end else begin
      ov_q <= ov_n;
      oc_q <= oc_n;
      ow_q <= ow_n;
    end
  end

  assign out_valid = ov_q;
  assign out_cmd   = oc_q;
  assign out_word  = ow_q;

  // R8: a stalled word stays in place until taken.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_cmd)));

  // R9: nothing is accepted while the output is stalled.
  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_ready) |-> (!ch_ready && !loc_ready));

  // R2: command beats carry only a low byte.
  p_cmd_byte_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_cmd) |-> (out_word[31:8] == 24'h0));

endmodule

// File: tb/lcd_text_render_tb.sv
`timescale 1ns/1ps
module lcd_text_render_tb;

  localparam int X_W = 6;

  logic        clk, rst_n;
  logic        ch_valid, ch_last, ch_ready;
  logic [7:0]  ch_code;
  logic        loc_valid, loc_ready;
  logic [X_W-1:0] loc_x;
  logic [1:0]  loc_y;
  logic        out_valid, out_cmd, out_ready;
  logic [31:0] out_word;

  int checks, errors;
  int stall_mode, cyc, hold_err;
  bit prev_stall;
  logic [31:0] prev_word;
  logic [31:0] cap_w [256];
  bit          cap_c [256];
  int          cap_n;
  logic [31:0] exp_w [256];
  bit          exp_c [256];
  int          exp_n;
  logic [7:0]  pend [4];
  int          pend_n;
  bit          done;

  lcd_text_render #(.X_W(X_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ch_valid(ch_valid), .ch_code(ch_code), .ch_last(ch_last), .ch_ready(ch_ready),
    .loc_valid(loc_valid), .loc_x(loc_x), .loc_y(loc_y), .loc_ready(loc_ready),
    .out_valid(out_valid), .out_cmd(out_cmd), .out_word(out_word), .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Downstream model: drives out_ready and records each transfer that the
  // coming rising edge will complete; also watches the hold rule.
  initial begin
    out_ready = 1'b0; cyc = 0; hold_err = 0; prev_stall = 1'b0; prev_word = '0; cap_n = 0;
    forever begin
      @(negedge clk);
      out_ready = (stall_mode == 0) || ((cyc % 3) != 1);
      cyc++;
      if (prev_stall && (!out_valid || out_word !== prev_word)) hold_err++;
      prev_stall = out_valid && !out_ready;
      prev_word  = out_word;
      if (out_valid && out_ready) begin
        cap_w[cap_n] = out_word;
        cap_c[cap_n] = out_cmd;
        cap_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] ref_glyph(input logic [7:0] c);
    case (c)
      8'h21: return 40'h00005F0000;
      8'h31: return 40'h00427F4000;
      8'h41: return 40'h7E1111117E;
      8'h48: return 40'h7F0808087F;
      8'h7A: return 40'h4464544C44;
      8'h7F: return 40'h0000070507;
      default: return 40'h0;
    endcase
  endfunction

  task automatic exp_cmd(input logic [7:0] b);
    exp_w[exp_n] = {24'h0, b}; exp_c[exp_n] = 1'b1; exp_n++;
  endtask

  task automatic exp_byte(input logic [7:0] b);
    pend[pend_n] = b; pend_n++;
    if (pend_n == 4) begin
      exp_w[exp_n] = {pend[0], pend[1], pend[2], pend[3]}; exp_c[exp_n] = 1'b0; exp_n++;
      pend_n = 0;
    end
  endtask

  task automatic exp_char(input logic [7:0] c, input bit last);
    logic [39:0] g = ref_glyph(c);
    for (int k = 0; k < 5; k++) exp_byte(g[39-8*k -: 8]);
    exp_byte(8'h00);
    if (last && pend_n != 0) begin
      for (int k = pend_n; k < 4; k++) pend[k] = 8'h00;
      exp_w[exp_n] = {pend[0], pend[1], pend[2], pend[3]}; exp_c[exp_n] = 1'b0; exp_n++;
      pend_n = 0;
    end
  endtask

  task automatic exp_loc(input int x, input int y);
    logic [7:0] col = 8'(x * 6);
    exp_cmd(8'hB0 | 8'(y & 3));
    exp_cmd(8'h10 | {4'h0, col[7:4]});
    exp_cmd({4'h0, col[3:0]});
  endtask

  task automatic drv_char(input logic [7:0] c, input bit last);
    bit got;
    @(negedge clk);
    ch_valid = 1'b1; ch_code = c; ch_last = last;
    got = 1'b0;
    while (!got) begin
      #1 got = ch_ready;
      @(negedge clk);
    end
    ch_valid = 1'b0;
    exp_char(c, last);
  endtask

  task automatic drv_loc(input int x, input int y);
    bit got;
    @(negedge clk);
    loc_valid = 1'b1; loc_x = X_W'(x); loc_y = 2'(y);
    got = 1'b0;
    while (!got) begin
      #1 got = loc_ready;
      @(negedge clk);
    end
    loc_valid = 1'b0;
    exp_loc(x, y);
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic check_stream(input string req);
    chk(cap_n == exp_n, {req, " word count"}, 32'(cap_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_w[i] === exp_w[i] && cap_c[i] === exp_c[i], req,
          {cap_w[i][30:0], cap_c[i]}, {exp_w[i][30:0], exp_c[i]});
    end
    cap_n = 0; exp_n = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid === 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    chk(ch_ready === 1'b1, "R1 ch_ready", 32'(ch_ready), 32'd1);
    chk(loc_ready === 1'b1, "R1 loc_ready", 32'(loc_ready), 32'd1);
  endtask

  task automatic t_locate();
    drv_loc(0, 1);
    drv_loc(7, 6);
    drv_loc(42, 3);
    settle();
    check_stream("R2");
  endtask

  task automatic t_glyphs();
    drv_char(8'h41, 1'b1);        // R3, R7: 6 bytes, padded second word
    settle();
    check_stream("R3");
    drv_char(8'h48, 1'b0);        // R4, R6: 12 bytes fill three words exactly
    drv_char(8'h31, 1'b1);
    settle();
    check_stream("R6");
    drv_char(8'h7F, 1'b1);
    settle();
    check_stream("R4");
  endtask

  task automatic t_range();
    drv_char(8'h0A, 1'b0);
    drv_char(8'h80, 1'b0);
    drv_char(8'hFF, 1'b1);
    settle();
    check_stream("R5");
  endtask

  task automatic t_stall();
    stall_mode = 1;
    hold_err = 0;
    drv_loc(3, 2);
    drv_char(8'h7A, 1'b0);
    drv_char(8'h7F, 1'b0);
    drv_char(8'h21, 1'b1);        // 18 bytes: R7 pad of two zero bytes
    settle();
    stall_mode = 0;
    settle();
    check_stream("R8");
    chk(hold_err == 0, "R8 hold", 32'(hold_err), 32'd0);
  endtask

  task automatic t_block();
    drv_char(8'h41, 1'b0);
    #1;
    chk(ch_ready === 1'b0, "R9 busy ch_ready", 32'(ch_ready), 32'd0);
    settle();
    #1;
    chk(loc_ready === 1'b0, "R9 partial loc_ready", 32'(loc_ready), 32'd0);
    chk(ch_ready === 1'b1, "R9 idle ch_ready", 32'(ch_ready), 32'd1);
    drv_char(8'h21, 1'b1);
    settle();
    #1;
    chk(loc_ready === 1'b1, "R9 flushed loc_ready", 32'(loc_ready), 32'd1);
    check_stream("R9");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0; stall_mode = 0;
    exp_n = 0; pend_n = 0;
    ch_valid = 1'b0; ch_code = 8'h00; ch_last = 1'b0;
    loc_valid = 1'b0; loc_x = '0; loc_y = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_locate();
    t_glyphs();
    t_range();
    t_stall();
    t_block();
    finish_run();
  end

endmodule